// File: doc/BRIEF.md
# Two-Wire EEPROM Random-Read Sequencer

This block fetches bytes from a two-wire serial EEPROM that takes a 16-bit word address. It drives the bus as an open-drain master through three outputs: a clock level, a data level and a data-drive enable. It samples the resolved data line on one input. Each byte is fetched with a full random read. The block sends a start and the write-form device byte. It then sends the address high and low bytes, issues a repeated start and the read-form device byte, and clocks in eight data bits. A stop condition closes every transaction.

A run wrapper sits on top. One start pulse and a base address make it fetch `RUN_LEN` consecutive bytes, which is six by default and gives a 48-bit station address from base 0x008E. It pulses done once with the assembled word and an error flag. The run ends at the first byte whose transaction sees a missing acknowledge. Every pin change is held for `CLK_DIV` system clocks, so the bus phases can be stretched to a microsecond or more.

Top module: `ee_seq_reader`

## Requirements
- R1: Out of reset the block is idle: busy_o=0, done_o=0, scl_o=0, sda_o=1, sda_oe_o=0.
- R2: A start is sda_o falling while scl_o is high, and a stop is sda_o rising while scl_o is high. scl_o never changes in the same cycle as sda_o or sda_oe_o, so a byte read shows exactly two starts: the first start and the repeated one.
- R3: Each byte read sends, in this order: start, {DEV_ADDR,0} (0xA0 by default), address[15:8], address[7:0], repeated start, {DEV_ADDR,1} (0xA1), and then eight received bits. Every byte goes out most-significant bit first, with the data set while the clock is low before the clock pulse.
- R4: After each sent byte, sda_oe_o is 0 during a ninth clock pulse, and the line level sampled during that pulse is the acknowledge (0 = acknowledged). sda_oe_o is also 0 during the eight received-data pulses, which build the byte MSB first.
- R5: If any acknowledge reads 1, no further byte or repeated start is sent. The transaction goes straight to the stop and the run reports err_o=1.
- R6: Every transaction ends with a stop condition, whether it succeeds or fails, and the clock is left low afterwards.
- R7: A run reads addresses base, base+1, …, base+RUN_LEN-1, with the address wrapping modulo 2^16. Byte i is placed at data_o[8*(RUN_LEN-1-i) +: 8], so the first byte is most significant.
- R8: A run stops at the first failed byte: after a failure in byte k no transaction for byte k+1 is started.
- R9: Any level on scl_o, sda_o or sda_oe_o is held for at least CLK_DIV clock cycles.
- R10: start_i is taken only while busy_o is 0. A start pulse during a run changes neither the addresses read nor the result.
- R11: done_o is a one-cycle pulse per run, err_o is high only together with done_o, and busy_o is low in the cycle after done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Run request, taken when idle |
| base_addr_i | input | 16 | First EEPROM address of the run |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Run failed on a missing acknowledge (with done_o) |
| data_o | output | 8*RUN_LEN | Fetched bytes, first byte most significant |
| scl_o | output | 1 | Bus clock level |
| sda_o | output | 1 | Bus data level when driven |
| sda_oe_o | output | 1 | Bus data drive enable |
| sda_i | input | 1 | Resolved bus data line |

## Verification
Some rules are checked on every cycle. Pin levels must last at least CLK_DIV cycles. A clock edge must never coincide with a data or enable change, which keeps start and stop conditions clean. Done must be a single-cycle pulse, err_o may only appear with it, the bus clock must be low while idle, and a run may only begin after a start request.

Other behaviour can only be shown by the bench's behavioural EEPROM model. That covers the byte order and content on the wire, acknowledge release, the early stop after a missing acknowledge at each of the four acknowledge points in each byte of a run, address wrap, and a start pulse ignored during a run.

// File: rtl/ee_pkg.sv
`timescale 1ns/1ps
package ee_pkg;
  // one state per bus action; each action runs on a prescaler tick
  typedef enum logic [4:0] {
    SQ_IDLE,
    SQ_S_REL, SQ_S_CH, SQ_S_DL, SQ_S_CL,
    SQ_T_PRE, SQ_T_BIT, SQ_T_CH, SQ_T_CL, SQ_T_REL, SQ_T_AH, SQ_T_AL,
    SQ_R_CH, SQ_R_CL,
    SQ_P_DL, SQ_P_CH, SQ_P_DH, SQ_P_CL
  } seq_e;
endpackage

// File: rtl/ee_tick.sv
`timescale 1ns/1ps
module ee_tick #(
  parameter int unsigned DIV = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int W = $clog2(DIV + 1);
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i)           cnt_q <= '0;
    else if (cnt_q == LAST)    cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/ee_byte_rd.sv
`timescale 1ns/1ps
module ee_byte_rd
  import ee_pkg::*;
#(
  parameter int unsigned CLK_DIV  = 200,
  parameter logic [6:0]  DEV_ADDR = 7'h50
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        go_i,
  input  logic [15:0] addr_i,
  output logic        done_o,
  output logic        err_o,
  output logic [7:0]  data_o,
  output logic        scl_o,
  output logic        sda_o,
  output logic        sda_oe_o,
  input  logic        sda_i
);
  localparam logic [7:0] DEV_WR = {DEV_ADDR, 1'b0};
  localparam logic [7:0] DEV_RD = {DEV_ADDR, 1'b1};

  seq_e        st_q;
  logic [1:0]  idx_q;
  logic [2:0]  bit_q;
  logic [7:0]  sh_q, rx_q, tx_byte;
  logic [15:0] addr_q;
  logic        err_q, done_q, tick;

  ee_tick #(.DIV(CLK_DIV)) tick_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (st_q != SQ_IDLE),
    .tick_o (tick)
  );

  always_comb begin
    case (idx_q)
      2'd0:    tx_byte = DEV_WR;
      2'd1:    tx_byte = addr_q[15:8];
      2'd2:    tx_byte = addr_q[7:0];
      default: tx_byte = DEV_RD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= SQ_IDLE;
      idx_q    <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      rx_q     <= '0;
      addr_q   <= '0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
      scl_o    <= 1'b0;
      sda_o    <= 1'b1;
      sda_oe_o <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st_q == SQ_IDLE) begin
        if (go_i) begin
          addr_q <= addr_i;
          idx_q  <= '0;
          err_q  <= 1'b0;
          st_q   <= SQ_S_REL;
        end
      end else if (tick) begin
        case (st_q)
          SQ_S_REL: begin sda_o <= 1'b1; sda_oe_o <= 1'b1; st_q <= SQ_S_CH; end
          SQ_S_CH:  begin scl_o <= 1'b1; st_q <= SQ_S_DL; end
          SQ_S_DL:  begin sda_o <= 1'b0; st_q <= SQ_S_CL; end
          SQ_S_CL:  begin scl_o <= 1'b0; st_q <= SQ_T_PRE; end
          SQ_T_PRE: begin
            sda_o <= 1'b0; sda_oe_o <= 1'b1;
            sh_q  <= tx_byte; bit_q <= 3'd7;
            st_q  <= SQ_T_BIT;
          end
          SQ_T_BIT: begin sda_o <= sh_q[7]; st_q <= SQ_T_CH; end
          SQ_T_CH:  begin scl_o <= 1'b1; st_q <= SQ_T_CL; end
          SQ_T_CL: begin
            scl_o <= 1'b0;
            sh_q  <= {sh_q[6:0], 1'b0};
            if (bit_q == 3'd0) st_q <= SQ_T_REL;
            else begin bit_q <= bit_q - 1'b1; st_q <= SQ_T_BIT; end
          end
          SQ_T_REL: begin sda_o <= 1'b0; sda_oe_o <= 1'b0; st_q <= SQ_T_AH; end
          SQ_T_AH:  begin scl_o <= 1'b1; st_q <= SQ_T_AL; end
          SQ_T_AL: begin
            scl_o <= 1'b0;
            if (sda_i) begin
              err_q <= 1'b1;
              st_q  <= SQ_P_DL;
            end else begin
              case (idx_q)
                2'd2: begin idx_q <= 2'd3; st_q <= SQ_S_REL; end
                2'd3: begin bit_q <= 3'd7; st_q <= SQ_R_CH; end
                default: begin idx_q <= idx_q + 1'b1; st_q <= SQ_T_PRE; end
              endcase
            end
          end
          SQ_R_CH:  begin scl_o <= 1'b1; st_q <= SQ_R_CL; end
          SQ_R_CL: begin
            rx_q  <= {rx_q[6:0], sda_i};
            scl_o <= 1'b0;
            if (bit_q == 3'd0) st_q <= SQ_P_DL;
            else begin bit_q <= bit_q - 1'b1; st_q <= SQ_R_CH; end
          end
          SQ_P_DL:  begin sda_o <= 1'b0; sda_oe_o <= 1'b1; st_q <= SQ_P_CH; end
          SQ_P_CH:  begin scl_o <= 1'b1; st_q <= SQ_P_DH; end
          SQ_P_DH:  begin sda_o <= 1'b1; st_q <= SQ_P_CL; end
          SQ_P_CL:  begin scl_o <= 1'b0; done_q <= 1'b1; st_q <= SQ_IDLE; end
          default:  st_q <= SQ_IDLE;
        endcase
      end
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;
  assign data_o = rx_q;
endmodule

// File: rtl/ee_run.sv
`timescale 1ns/1ps
module ee_run #(
  parameter int unsigned RUN_LEN = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [15:0]            base_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   err_o,
  output logic [8*RUN_LEN-1:0]   data_o,
  output logic                   go_o,
  output logic [15:0]            addr_o,
  input  logic                   b_done_i,
  input  logic                   b_err_i,
  input  logic [7:0]             b_data_i
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic                 active_q, go_q, done_q, err_q;
  logic [CW-1:0]        cnt_q;
  logic [15:0]          addr_q;
  logic [8*RUN_LEN-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      go_q     <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      cnt_q    <= '0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (!active_q) begin
        if (start_i) begin
          active_q <= 1'b1;
          addr_q   <= base_i;
          cnt_q    <= '0;
          go_q     <= 1'b1;
        end
      end else if (b_done_i) begin
        if (b_err_i) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
          err_q    <= 1'b1;
        end else begin
          for (int i = 0; i < int'(RUN_LEN); i++)
            if (cnt_q == CW'(i)) data_q[8*(int'(RUN_LEN)-1-i) +: 8] <= b_data_i;
          if (cnt_q == LAST) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            cnt_q  <= cnt_q + 1'b1;
            addr_q <= addr_q + 16'd1;
            go_q   <= 1'b1;
          end
        end
      end
    end
  end

  assign busy_o = active_q;
  assign done_o = done_q;
  assign err_o  = err_q;
  assign data_o = data_q;
  assign go_o   = go_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/ee_seq_reader.sv
`timescale 1ns/1ps
module ee_seq_reader #(
  parameter int unsigned CLK_DIV  = 200,
  parameter int unsigned RUN_LEN  = 6,
  parameter logic [6:0]  DEV_ADDR = 7'h50
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [15:0]          base_addr_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 err_o,
  output logic [8*RUN_LEN-1:0] data_o,
  output logic                 scl_o,
  output logic                 sda_o,
  output logic                 sda_oe_o,
  input  logic                 sda_i
);
  logic        go, b_done, b_err;
  logic [15:0] addr;
  logic [7:0]  b_data;

  ee_run #(.RUN_LEN(RUN_LEN)) run_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .base_i   (base_addr_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .err_o    (err_o),
    .data_o   (data_o),
    .go_o     (go),
    .addr_o   (addr),
    .b_done_i (b_done),
    .b_err_i  (b_err),
    .b_data_i (b_data)
  );

  ee_byte_rd #(.CLK_DIV(CLK_DIV), .DEV_ADDR(DEV_ADDR)) byte_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (go),
    .addr_i   (addr),
    .done_o   (b_done),
    .err_o    (b_err),
    .data_o   (b_data),
    .scl_o    (scl_o),
    .sda_o    (sda_o),
    .sda_oe_o (sda_oe_o),
    .sda_i    (sda_i)
  );
endmodule

// File: rtl/ee_seq_reader_chk.sv
`timescale 1ns/1ps
module ee_seq_reader_chk #(
  parameter int unsigned CLK_DIV = 200
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic err_o,
  input logic scl_o,
  input logic sda_o,
  input logic sda_oe_o
);
  localparam int HW = $clog2(CLK_DIV + 1) + 1;

  logic [2:0]    pins_q;
  logic [HW-1:0] hold_q;
  logic [2:0]    pins;
  assign pins = {scl_o, sda_o, sda_oe_o};

  // cycles the previous pin level has been visible
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pins_q <= 3'b010;
      hold_q <= HW'(CLK_DIV);
    end else begin
      pins_q <= pins;
      if (pins != pins_q)               hold_q <= HW'(1);
      else if (hold_q < HW'(CLK_DIV))   hold_q <= hold_q + 1'b1;
    end
  end

  AST_PIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins != pins_q) |-> (hold_q >= HW'(CLK_DIV))); // R9

  AST_CLK_DATA_APART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_o != $past(scl_o)) |-> (sda_o == $past(sda_o) && sda_oe_o == $past(sda_oe_o))); // R2

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11

  AST_ERR_ONLY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o); // R11

  AST_IDLE_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !scl_o); // R6

  AST_RUN_NEEDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i)); // R10
endmodule

bind ee_seq_reader ee_seq_reader_chk #(.CLK_DIV(CLK_DIV)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .err_o    (err_o),
  .scl_o    (scl_o),
  .sda_o    (sda_o),
  .sda_oe_o (sda_oe_o)
);

// File: tb/ee_seq_reader_tb_top.sv
`timescale 1ns/1ps
module ee_seq_reader_tb_top;
  localparam int unsigned DIV = 2;
  localparam int RL = 6;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] base = 16'h0;
  logic busy, done, err, scl, sda_o, sda_oe;
  logic [8*RL-1:0] data;
  logic slv_low = 1'b0;
  wire  line;

  assign line = (sda_oe ? sda_o : 1'b1) & ~slv_low;

  always #2.5 clk = ~clk;

  ee_seq_reader #(.CLK_DIV(DIV), .RUN_LEN(RL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_addr_i(base),
    .busy_o(busy), .done_o(done), .err_o(err), .data_o(data),
    .scl_o(scl), .sda_o(sda_o), .sda_oe_o(sda_oe), .sda_i(line)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem(input logic [15:0] a);
    logic [15:0] p;
    p = {8'h0, a[7:0]} * 16'd7;
    return p[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  // behavioural EEPROM slave
  int bcnt = 0, slot = 0, rbit = 0, txn = 0, n_start = 0, n_stop = 0, ack_oe_bad = 0;
  int nack_txn = -1, nack_slot = -1;
  bit active = 0, fresh = 0, reading = 0, to_read = 0, ok;
  logic [7:0] sh = 8'h0, txb = 8'h0;
  logic [15:0] ptr = 16'h0;

  always @(negedge line) if (scl) begin
    n_start++; active = 1; fresh = 1; bcnt = 0; reading = 0; to_read = 0;
  end

  always @(posedge line) if (scl && active) begin
    n_stop++; active = 0; slot = 0; txn++; slv_low = 0;
  end

  always @(posedge scl) if (active) begin
    if (reading || bcnt == 8) begin
      if (sda_oe) ack_oe_bad++;
    end
    if (!reading && bcnt < 8) sh = {sh[6:0], line};
  end

  always @(negedge scl) if (active) begin
    if (fresh) fresh = 0;
    else if (reading) begin
      if (rbit == 0) begin slv_low = 0; reading = 0; end
      else begin rbit--; slv_low = ~txb[rbit]; end
    end else if (bcnt < 8) begin
      bcnt++;
      if (bcnt == 8) begin
        ok = 1;
        case (slot)
          0: ok = (sh == 8'hA0);
          1: ptr[15:8] = sh;
          2: ptr[7:0] = sh;
          default: ok = (sh == 8'hA1);
        endcase
        if (txn == nack_txn && slot == nack_slot) ok = 0;
        to_read = ok && (slot == 3);
        slv_low = ok;
      end
    end else begin
      slv_low = 0; bcnt = 0; slot++;
      if (to_read) begin
        reading = 1; to_read = 0; txb = mem(ptr); rbit = 7; slv_low = ~txb[7];
      end
    end
  end

  // pin hold monitor
  int cyc = 0, pm_last = 0, min_hold = 1000000;
  logic [2:0] pm_prev = 3'b010;
  always @(posedge clk) cyc++;
  always @(negedge clk) begin
    if ({scl, sda_o, sda_oe} != pm_prev) begin
      if (cyc - pm_last < min_hold) min_hold = cyc - pm_last;
      pm_last = cyc;
      pm_prev = {scl, sda_o, sda_oe};
    end
  end

  task automatic do_run(input logic [15:0] b, input int ntx, input int nsl, input bit mid);
    logic [8*RL-1:0] exp_data;
    bit exp_err;
    int exp_stop, exp_start, w;
    exp_err = (ntx >= 0);
    nack_txn = ntx; nack_slot = nsl; txn = 0; n_start = 0; n_stop = 0;
    ack_oe_bad = 0; min_hold = 1000000;
    for (int i = 0; i < RL; i++) exp_data[8*(RL-1-i) +: 8] = mem(b + 16'(i));
    exp_stop  = exp_err ? ntx + 1 : RL;
    exp_start = exp_err ? 2*ntx + ((nsl == 3) ? 2 : 1) : 2*RL;
    @(negedge clk); base = b; start = 1'b1;
    @(negedge clk); start = 1'b0; base = 16'h0;
    if (mid) begin
      repeat (400) @(negedge clk);
      chk(busy == 1'b1, "R10", "busy during run", longint'(busy), 1);
      base = 16'h4000; start = 1'b1;
      @(negedge clk); start = 1'b0; base = 16'h0;
    end
    w = 0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    if (!done) begin
      chk(1'b0, "R11", "run timeout", 0, 1);
      return;
    end
    chk(err == exp_err, "R5", "err flag", longint'(err), longint'(exp_err));
    if (!exp_err)
      chk(data == exp_data, mid ? "R10" : "R7", "run data", longint'(data), longint'(exp_data));
    chk(n_stop == exp_stop, exp_err ? "R8" : "R6", "stop count", n_stop, exp_stop);
    chk(n_start == exp_start, exp_err ? "R5" : "R3", "start count", n_start, exp_start);
    chk(ack_oe_bad == 0, "R4", "drive during ack/read pulses", ack_oe_bad, 0);
    chk(min_hold >= int'(DIV), "R9", "min pin hold", min_hold, DIV);
    @(negedge clk);
    chk(!done && !err && !busy, "R11", "done/err/busy after pulse",
        longint'({done, err, busy}), 0);
    repeat (4) @(negedge clk);
    chk(scl == 1'b0 && n_stop == exp_stop, "R6", "bus quiet after run", longint'(scl), 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0, "R1", "busy/done after reset", longint'({busy, done}), 0);
    chk(scl == 0 && sda_o == 1 && sda_oe == 0, "R1", "pins after reset",
        longint'({scl, sda_o, sda_oe}), 3'b010);
    // R7 address sweep, first base is the station-address location
    for (int i = 0; i < 8; i++) do_run(16'(32'h008E + i * 32'h2493), -1, -1, 1'b0);
    do_run(16'hFFFC, -1, -1, 1'b0);  // R7 wrap
    do_run(16'h0100, -1, -1, 1'b1);  // R10 start while busy
    // R5/R8 missing acknowledge at every slot of every byte
    for (int t = 0; t < RL; t++)
      for (int s = 0; s < 4; s++) do_run(16'(32'h0200 + t), t, s, 1'b0);
    nack_txn = -1; nack_slot = -1;
    do_run(16'h008E, -1, -1, 1'b0);  // R3 recovery after failures
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule